// File: doc/BRIEF.md
# Chained Shift-Register Output Driver

This block feeds a daisy chain of serial-in, parallel-out shift registers that carry output storage latches. Three pins do the work: a shift clock, a serial data line and a parallel load strobe. A host places up to `MAX_BYTES` bytes on a wide data port, says how many are valid and pulses a start strobe. The driver then clocks every bit of those bytes into the chain. Once the chain is full it pulses the load line, so that all register outputs change together. A busy flag covers the whole transfer, and a one-cycle done pulse marks its end.

The host numbers the bytes from the register nearest the driver outward. The chain, however, must receive the most remote register's byte first. The driver therefore walks the bytes from the highest index down to the lowest, and sends each byte MSB first. A delay count, sampled at start, sets how many system clock cycles every level on the pins is held. This count lets the pin timing match long or heavily loaded wiring. Parameters set the active level of each pin. A further parameter drops the load pulse altogether, for chains that have no storage stage or whose load input is tied active.

Top module: `chain_out_driver`

## Requirements
- R1: A start is accepted only in a cycle where the block is idle and `nbytes` lies between 1 and `MAX_BYTES`. A start with `nbytes` equal to 0 or above `MAX_BYTES` is ignored, and `busy` stays low.
- R2: A transfer of N bytes produces exactly 8N active clock edges. Byte k (k = 1..N) lives in `data_in[8k-1:8k-8]`. Bytes go out from k = N down to k = 1, each MSB first, so the bits appear in the order `data_in[8N-1]` down to `data_in[0]`.
- R3: Let D be the sampled `step_dly`, where a value of 0 counts as 1. Counting `busy` cycles from 0, the clock for bit j (j from 0) becomes active at cycle D(2j+1) and returns inactive at cycle D(2j+2). The data pin already holds that bit D cycles before the active edge and keeps it while the clock is active.
- R4: With the load enabled, exactly one load pulse occurs. It is D cycles wide and starts at busy cycle 16ND + D, which is D cycles after the last clock phase ends.
- R5: With `USE_LOAD` = 0, the load pin stays at its inactive level at all times, and `busy` lasts 16ND + D cycles.
- R6: `CLK_ACTIVE_HIGH`, `DATA_INVERT` and `LOAD_ACTIVE_HIGH` each set the level of their own pin independently. An inverted configuration produces the bitwise complement of the clock and data waveforms.
- R7: With the load enabled, `busy` stays high for exactly 16ND + 2D cycles. `done` is high for exactly the one cycle right after `busy` falls.
- R8: After reset the clock and load pins sit at their inactive levels, the data pin carries a logical 0, and `busy` and `done` are low.
- R9: A start raised while `busy` is high has no effect on the transfer under way. A start held high through the `done` cycle is accepted there, and `busy` rises again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a transfer |
| nbytes | input | CNT_W | Number of bytes to send, 1..MAX_BYTES |
| data_in | input | 8*MAX_BYTES | Byte k at bits [8k-1:8k-8], with byte 1 for the nearest register |
| step_dly | input | DLY_W | Cycles per pin level; 0 counts as 1 |
| sclk | output | 1 | Shift clock to the chain |
| sdat | output | 1 | Serial data to the chain |
| sload | output | 1 | Parallel load strobe to the chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The two events that can share a cycle are the end of one transfer and the start of the next. The bench holds `start` high across a whole transfer, so that the request is present in the `done` cycle. It then requires `busy` to be high in the very next cycle, while `done` has already dropped. A second overlap, a start request in the middle of a transfer, is judged by checking that the captured bit stream and the busy length still match the first request's data and size.

// File: rtl/cod_pkg.sv
package cod_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_TAIL,
    PH_LOAD
  } cod_phase_t;
endpackage

// File: rtl/cod_step_timer.sv
module cod_step_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic [DLY_W-1:0] reload_val,
  output logic             expire
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= reload_val - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == '0);

  // R3: a reload value is never zero, so no phase can be shorter than one cycle
  a_r3_reload_nonzero: assert property (@(posedge clk) disable iff (rst)
    reload |-> (reload_val != '0));
endmodule

// File: rtl/cod_bit_sequencer.sv
module cod_bit_sequencer
  import cod_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DLY_W     = 8,
  parameter bit USE_LOAD  = 1'b1,
  localparam int TOT_BITS = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int BIT_W    = $clog2(TOT_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNT_W-1:0]    nbytes,
  input  logic [TOT_BITS-1:0] data_in,
  input  logic [DLY_W-1:0]    step_dly,
  input  logic                expire,
  output logic                reload,
  output logic [DLY_W-1:0]    reload_val,
  output logic                clk_raw,
  output logic                dat_raw,
  output logic                ld_raw,
  output logic                busy_raw,
  output logic                done_raw
);
  cod_phase_t          phase;
  logic [BIT_W-1:0]    bitidx;
  logic [BIT_W-1:0]    nxt_idx;
  logic [BIT_W-1:0]    first_idx;
  logic [CNT_W+2:0]    tot_bits;
  logic [DLY_W-1:0]    dly_q;
  logic [DLY_W-1:0]    dly_eff;
  logic [TOT_BITS-1:0] shreg;
  logic                req_ok;
  logic                accept;

  assign tot_bits  = {nbytes, 3'b000};
  assign first_idx = BIT_W'(tot_bits - 1'b1);
  assign nxt_idx   = bitidx - 1'b1;
  assign req_ok    = (nbytes != '0) && (nbytes <= CNT_W'(MAX_BYTES));
  assign accept    = (phase == PH_IDLE) && start && req_ok;
  assign dly_eff   = (step_dly == '0) ? DLY_W'(1) : step_dly;

  always_comb begin
    reload     = accept || ((phase != PH_IDLE) && expire);
    reload_val = (phase == PH_IDLE) ? dly_eff : dly_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitidx   <= '0;
      dly_q    <= DLY_W'(1);
      shreg    <= '0;
      clk_raw  <= 1'b0;
      dat_raw  <= 1'b0;
      ld_raw   <= 1'b0;
      busy_raw <= 1'b0;
      done_raw <= 1'b0;
    end else begin
      done_raw <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            shreg    <= data_in;
            bitidx   <= first_idx;
            dly_q    <= dly_eff;
            dat_raw  <= data_in[first_idx];
            clk_raw  <= 1'b0;
            busy_raw <= 1'b1;
            phase    <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (expire) begin
            clk_raw <= 1'b1;
            phase   <= PH_HIGH;
          end
        end
        PH_HIGH: begin
          if (expire) begin
            clk_raw <= 1'b0;
            if (bitidx == '0) begin
              phase <= PH_TAIL;
            end else begin
              bitidx  <= nxt_idx;
              dat_raw <= shreg[nxt_idx];
              phase   <= PH_SETUP;
            end
          end
        end
        PH_TAIL: begin
          if (expire) begin
            if (USE_LOAD) begin
              ld_raw <= 1'b1;
              phase  <= PH_LOAD;
            end else begin
              busy_raw <= 1'b0;
              done_raw <= 1'b1;
              phase    <= PH_IDLE;
            end
          end
        end
        PH_LOAD: begin
          if (expire) begin
            ld_raw   <= 1'b0;
            busy_raw <= 1'b0;
            done_raw <= 1'b1;
            phase    <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: busy only rises after a valid start request
  a_r1_busy_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_raw) |-> ($past(start) && ($past(nbytes) != '0)));

  // R3: a running phase only advances when the step timer has run out
  a_r3_phase_on_expire: assert property (@(posedge clk) disable iff (rst)
    ((phase != $past(phase)) && ($past(phase) != PH_IDLE)) |-> $past(expire));

  // R3: data does not move while the clock is active
  a_r3_data_stable_clk: assert property (@(posedge clk) disable iff (rst)
    (clk_raw && $past(clk_raw)) |-> $stable(dat_raw));

  // R4: load only follows the last bit, with the clock inactive
  a_r4_load_at_end: assert property (@(posedge clk) disable iff (rst)
    ld_raw |-> ((bitidx == '0) && !clk_raw));

  // R7: done lasts one cycle
  a_r7_done_one: assert property (@(posedge clk) disable iff (rst)
    done_raw |=> !done_raw);

  // R9: latched data is frozen once a transfer runs
  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(shreg));
endmodule

// File: rtl/cod_pin_stage.sv
module cod_pin_stage #(
  parameter bit CLK_ACTIVE_HIGH  = 1'b1,
  parameter bit DATA_INVERT      = 1'b0,
  parameter bit LOAD_ACTIVE_HIGH = 1'b1,
  parameter bit USE_LOAD         = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_raw,
  input  logic dat_raw,
  input  logic ld_raw,
  input  logic busy_raw,
  input  logic done_raw,
  output logic sclk,
  output logic sdat,
  output logic sload,
  output logic busy,
  output logic done
);
  localparam logic CLK_IDLE = ~CLK_ACTIVE_HIGH;
  localparam logic LD_IDLE  = ~LOAD_ACTIVE_HIGH;
  localparam logic DAT_FLIP = DATA_INVERT;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= CLK_IDLE;
      sdat <= DAT_FLIP;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      sclk <= clk_raw ^ CLK_IDLE;
      sdat <= dat_raw ^ DAT_FLIP;
      busy <= busy_raw;
      done <= done_raw;
    end
  end

  generate
    if (USE_LOAD) begin : g_load
      always_ff @(posedge clk) begin
        if (rst) sload <= LD_IDLE;
        else     sload <= ld_raw ^ LD_IDLE;
      end
    end else begin : g_no_load
      always_ff @(posedge clk) begin
        sload <= LD_IDLE;
      end
      // R5: the sequencer never requests a load when it is disabled
      a_r5_no_load_request: assert property (@(posedge clk) disable iff (rst)
        !ld_raw);
    end
  endgenerate
endmodule

// File: rtl/chain_out_driver.sv
module chain_out_driver #(
  parameter int MAX_BYTES        = 8,
  parameter int DLY_W            = 8,
  parameter bit CLK_ACTIVE_HIGH  = 1'b1,
  parameter bit DATA_INVERT      = 1'b0,
  parameter bit LOAD_ACTIVE_HIGH = 1'b1,
  parameter bit USE_LOAD         = 1'b1,
  localparam int TOT_BITS = MAX_BYTES * 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNT_W-1:0]    nbytes,
  input  logic [TOT_BITS-1:0] data_in,
  input  logic [DLY_W-1:0]    step_dly,
  output logic                sclk,
  output logic                sdat,
  output logic                sload,
  output logic                busy,
  output logic                done
);
  logic             reload;
  logic [DLY_W-1:0] reload_val;
  logic             expire;
  logic             clk_raw, dat_raw, ld_raw, busy_raw, done_raw;

  cod_step_timer #(.DLY_W(DLY_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .reload     (reload),
    .reload_val (reload_val),
    .expire     (expire)
  );

  cod_bit_sequencer #(
    .MAX_BYTES (MAX_BYTES),
    .DLY_W     (DLY_W),
    .USE_LOAD  (USE_LOAD)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .nbytes     (nbytes),
    .data_in    (data_in),
    .step_dly   (step_dly),
    .expire     (expire),
    .reload     (reload),
    .reload_val (reload_val),
    .clk_raw    (clk_raw),
    .dat_raw    (dat_raw),
    .ld_raw     (ld_raw),
    .busy_raw   (busy_raw),
    .done_raw   (done_raw)
  );

  cod_pin_stage #(
    .CLK_ACTIVE_HIGH  (CLK_ACTIVE_HIGH),
    .DATA_INVERT      (DATA_INVERT),
    .LOAD_ACTIVE_HIGH (LOAD_ACTIVE_HIGH),
    .USE_LOAD         (USE_LOAD)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .clk_raw  (clk_raw),
    .dat_raw  (dat_raw),
    .ld_raw   (ld_raw),
    .busy_raw (busy_raw),
    .done_raw (done_raw),
    .sclk     (sclk),
    .sdat     (sdat),
    .sload    (sload),
    .busy     (busy),
    .done     (done)
  );

  // R7: done never coincides with busy
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/chain_out_driver_test.sv
module chain_out_driver_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] nbytes = '0;
  logic [63:0] data_in = '0;
  logic [7:0] step_dly = '0;
  logic sclk, sdat, sload, busy, done;
  logic a_sclk, a_sdat, a_sload, a_busy, a_done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_out_driver uut (
    .clk(clk), .rst(rst), .start(start), .nbytes(nbytes), .data_in(data_in),
    .step_dly(step_dly), .sclk(sclk), .sdat(sdat), .sload(sload),
    .busy(busy), .done(done)
  );

  chain_out_driver #(
    .CLK_ACTIVE_HIGH(1'b0), .DATA_INVERT(1'b1),
    .LOAD_ACTIVE_HIGH(1'b0), .USE_LOAD(1'b0)
  ) uut_alt (
    .clk(clk), .rst(rst), .start(start), .nbytes(nbytes), .data_in(data_in),
    .step_dly(step_dly), .sclk(a_sclk), .sdat(a_sdat), .sload(a_sload),
    .busy(a_busy), .done(a_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input int n, input int d, input logic [63:0] dat,
                          input bit poke);
    int deff, bcnt, abcnt, rises, lstart, lcnt, lerr;
    bit bad_rise, bad_fall, bad_alt, aload_bad, seen_done;
    logic prev;
    logic [63:0] got, mask;
    deff = (d == 0) ? 1 : d;
    bcnt = 0; abcnt = 0; rises = 0; lstart = -1; lcnt = 0; lerr = 0;
    bad_rise = 0; bad_fall = 0; bad_alt = 0; aload_bad = 0; seen_done = 0;
    got = '0;
    mask = (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 1);
    @(negedge clk);
    nbytes = 4'(n); step_dly = 8'(d); data_in = dat; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = sclk;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (poke && t == 10) begin start = 1'b1; data_in = ~dat; nbytes = 4'd1; end
      if (poke && t == 11) start = 1'b0;
      if (a_sload !== 1'b1) aload_bad = 1;
      if (a_busy) begin
        abcnt++;
        if (a_sclk !== ~sclk || a_sdat !== ~sdat) bad_alt = 1;
      end
      if (busy) begin
        if (sclk && !prev) begin
          if (bcnt != deff*(2*rises+1)) bad_rise = 1;
          got = {got[62:0], sdat};
          rises++;
        end
        if (!sclk && prev) begin
          if (bcnt != deff*(2*rises)) bad_fall = 1;
        end
        if (sload) begin
          if (lcnt == 0) lstart = bcnt;
          if (rises != 8*n) lerr = 1;
          lcnt++;
        end
        prev = sclk;
        bcnt++;
      end else if (bcnt > 0) begin
        seen_done = (done === 1'b1);
        break;
      end
    end
    chk(rises == 8*n, "R2", "active clock edge count", rises, 8*n);
    chk((got & mask) == (dat & mask), "R2", "shifted bit order", got & mask, dat & mask);
    chk(!bad_rise && !bad_fall, "R3", "clock phase timing", {bad_rise, bad_fall}, 0);
    chk(lstart == 16*n*deff + deff && lcnt == deff && !lerr, "R4", "load start/width",
        lstart*1000 + lcnt, (16*n*deff + deff)*1000 + deff);
    chk(bcnt == 16*n*deff + 2*deff, "R7", "busy length", bcnt, 16*n*deff + 2*deff);
    chk(seen_done, "R7", "done after busy falls", seen_done, 1);
    chk(abcnt == 16*n*deff + deff && !aload_bad, "R5", "no-load busy length / idle load",
        abcnt*2 + aload_bad, (16*n*deff + deff)*2);
    chk(!bad_alt, "R6", "inverted polarity pins", bad_alt, 0);
    @(negedge clk);
    chk(!done && !busy, "R7", "done single cycle", {done, busy}, 0);
  endtask

  task automatic try_invalid(input int n);
    bit seen;
    seen = 0;
    @(negedge clk);
    nbytes = 4'(n); step_dly = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (busy || a_busy) seen = 1;
    end
    chk(!seen, "R1", "invalid byte count ignored", seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 0 && sload == 0 && sdat == 0 && !busy && !done, "R8",
        "reset state default", {sclk, sload, sdat, busy, done}, 0);
    chk(a_sclk == 1 && a_sload == 1 && a_sdat == 1 && !a_busy, "R8",
        "reset state inverted", {a_sclk, a_sload, a_sdat, a_busy}, 3'b111 << 1);

    try_invalid(0);
    try_invalid(9);

    for (int n = 1; n <= MAXB; n++) begin
      for (int d = 0; d <= 3; d++) begin
        logic [63:0] pat;
        pat = 64'h0123_4567_89AB_CDEF ^ ({32'(n), 32'(d)} * 64'h9E37_79B9_7F4A_7C15);
        run_xfer(n, d, pat, 1'b0);
      end
    end

    // R9: mid-transfer start request is ignored
    run_xfer(3, 2, 64'h0000_0000_00C3_5AF0, 1'b1);
    run_xfer(1, 1, 64'h0000_0000_0000_0080, 1'b0);
    run_xfer(2, 1, 64'h0000_0000_0000_FFFF, 1'b0);

    // R9: start held through the done cycle restarts at once
    begin
      bit got_done, ok_next;
      got_done = 0; ok_next = 0;
      @(negedge clk);
      nbytes = 4'd1; step_dly = 8'd1; data_in = 64'h5A; start = 1'b1;
      for (int t = 0; t < 200; t++) begin
        @(negedge clk);
        if (done) begin got_done = 1; break; end
      end
      @(negedge clk);
      ok_next = busy && !done;
      start = 1'b0;
      chk(got_done && ok_next, "R9", "back-to-back restart", {got_done, ok_next}, 2'b11);
      for (int t = 0; t < 400; t++) begin
        @(negedge clk);
        if (!busy && !a_busy && !done) break;
      end
      repeat (3) @(negedge clk);
      chk(!busy && !a_busy, "R9", "idle after release", {busy, a_busy}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule